// File: doc/BRIEF.md
# Dual-Channel Transmit Queue with Interrupt Control

This block is the transmit half of a small Ethernet MAC register interface. Software loads frames into one of two independent byte queues through a single shared 32-bit data register. A channel-select register picks which queue receives each data write. Each channel also has a frame-length register and a start register. Once a start is accepted, the frame is streamed out one byte at a time on a valid/ready byte interface. A last flag marks the final byte, and a channel tag shows which queue is sending.

When a channel finishes sending, its queue and its length are cleared and its completion flag is raised. A receive-side event input raises a third flag. The three flags are combined with an enable mask into one interrupt line. Setting the reset bit in the control register returns every register and both queues to their reset state.

A small scheduler runs the output. Its states are `S_IDLE`, `S_SEND0` and `S_SEND1`, and it has these transitions:
- **LAUNCH0**: from idle to `S_SEND0` when channel 0 is queued and the sink is ready.
- **LAUNCH1**: from idle to `S_SEND1` when channel 1 is queued, channel 0 is not, and the sink is ready.
- **FINISH**: from either send state back to idle when the last byte is accepted.
- **ABORT**: from any state back to idle on a software reset.

Top module: `txq_dual_tx`

## Requirements
- R1: The channel-select register is at address 1. A write of 0 or 1 selects that channel; any value of 2 or more selects channel 0. Reading address 1 returns the selected channel.
- R2: A write to the data register (address 6) appends 4 bytes to the selected queue, least significant byte first. Bytes leave the queue in the order they were written.
- R3: If the selected queue has fewer than 4 bytes free, the whole data write is dropped and the queue content does not change.
- R4: The length registers are at address 2 (channel 0) and address 3 (channel 1). A written value larger than the queue size is stored as the queue size. Both registers can be read back.
- R5: Writing the start register with bit 0 set starts a send. Channel 0's start register is at address 4 and channel 1's at address 5. The start is accepted only when the transmit-enable bit (control register, address 0, bit 0) is set. The send covers the smaller of the programmed length and the queue fill, and a length of zero sends nothing.
- R6: When a send completes, that channel's queue is emptied, including bytes beyond the sent length, and its length register reads 0.
- R7: When a channel's last byte is accepted, that channel's status bit is set. The status register is at address 8: bit 0 is channel 0, bit 1 is channel 1, bit 2 is the receive event.
- R8: The irq output is high exactly when some status bit and the matching bit of the enable register (address 7, bits 2:0) are both 1. It follows an enable write on the next cycle.
- R9: Writing the status register clears each bit written as 1 and leaves the others unchanged.
- R10: A one-cycle pulse on rx_event sets status bit 2.
- R11: Writing the control register with bit 1 set clears every register and both queues and aborts any send in progress. Bit 0 of that same write is still stored as transmit enable; bit 1 always reads back 0. After reset every register reads 0, irq is low and tx_valid is low.
- R12: While sending, a byte moves on every cycle in which tx_ready is high. While tx_ready is low, tx_data, tx_last and tx_chan hold. tx_last is high only on the final byte.
- R13: Queued sends begin only when tx_ready is high. If both channels are queued at that point, channel 0 is sent completely before channel 1.
- R14: A start written to a channel that is already queued or sending is ignored. The frame that is already in flight keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rx_event | input | 1 | Receive-side event pulse |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_chan | output | 1 | Channel that owns the current byte |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 64-byte queue per channel instead of the default 2048 bytes. With that size, a completely full queue and a dropped 17th word take only a few dozen register writes. The same size makes the length clamp boundary (any value above 64) cheap to reach. A scoreboard checks every streamed byte, including its channel tag and last flag. Those expected bytes come from a model of the two queues that applies the drop, clamp and discard rules.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int NCH   = 2;
    localparam int NSRC  = 3;

    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_CHSEL = 4'd1;
    localparam logic [3:0] A_LEN0  = 4'd2;
    localparam logic [3:0] A_GO0   = 4'd4;
    localparam logic [3:0] A_DATA  = 4'd6;
    localparam logic [3:0] A_IEN   = 4'd7;
    localparam logic [3:0] A_ISTAT = 4'd8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SEND0 = 2'd1,
        S_SEND1 = 2'd2
    } send_state_e;
endpackage

// File: rtl/txq_byte_fifo.sv
module txq_byte_fifo #(
    parameter int DEPTH_BYTES = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [31:0]                  push_word,
    input  logic                         pop,
    output logic [7:0]                   head_byte,
    output logic [$clog2(DEPTH_BYTES):0] level
);
    localparam int WORDS = DEPTH_BYTES / 4;
    localparam int WA    = $clog2(WORDS);
    localparam int BA    = $clog2(DEPTH_BYTES);
    localparam int LW    = BA + 1;

    logic [31:0]   mem [WORDS];
    logic [WA-1:0] wp;
    logic [BA-1:0] rp;
    logic          accept;
    logic [31:0]   head_word;

    assign accept    = push && (level <= LW'(DEPTH_BYTES - 4));
    assign head_word = mem[rp[BA-1:2]];
    assign head_byte = head_word[{rp[1:0], 3'b000} +: 8];

    always_ff @(posedge clk) begin
        if (accept && !flush) mem[wp] <= push_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (accept) wp <= wp + 1'b1;
            if (pop)    rp <= rp + 1'b1;
            level <= level + (accept ? LW'(4) : LW'(0)) - (pop ? LW'(1) : LW'(0));
        end
    end
endmodule

// File: rtl/txq_send_sched.sv
module txq_send_sched
    import txq_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    srst,
    input  logic [NCH-1:0]          go,
    input  logic [NCH-1:0][LW-1:0]  go_len,
    input  logic                    tx_ready,
    output logic                    tx_valid,
    output logic                    tx_last,
    output logic                    tx_chan,
    output logic [NCH-1:0]          pop,
    output logic [NCH-1:0]          done,
    output logic [NCH-1:0]          busy
);
    send_state_e             state, nxt;
    logic [NCH-1:0]          pend;
    logic [NCH-1:0][LW-1:0]  plen;
    logic [LW-1:0]           rem;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (tx_ready && pend[0])      nxt = S_SEND0;   // LAUNCH0
                else if (tx_ready && pend[1]) nxt = S_SEND1;   // LAUNCH1
            end
            S_SEND0, S_SEND1: begin
                if (tx_ready && rem == LW'(1)) nxt = S_IDLE;   // FINISH
            end
            default: nxt = S_IDLE;
        endcase
        if (srst) nxt = S_IDLE;                                // ABORT
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            pend  <= '0;
            plen  <= '0;
            rem   <= '0;
        end else if (srst) begin
            state <= S_IDLE;
            pend  <= '0;
            plen  <= '0;
            rem   <= '0;
        end else begin
            state <= nxt;
            for (int c = 0; c < NCH; c++) begin
                if (go[c]) begin
                    pend[c] <= 1'b1;
                    plen[c] <= go_len[c];
                end
            end
            if (state == S_IDLE && nxt == S_SEND0) begin
                pend[0] <= 1'b0;
                rem     <= plen[0];
            end else if (state == S_IDLE && nxt == S_SEND1) begin
                pend[1] <= 1'b0;
                rem     <= plen[1];
            end else if (tx_valid && tx_ready) begin
                rem <= rem - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = (state != S_IDLE);
        tx_chan  = (state == S_SEND1);
        tx_last  = tx_valid && (rem == LW'(1));
        for (int c = 0; c < NCH; c++) begin
            pop[c]  = tx_valid && tx_ready && (tx_chan == 1'(c));
            done[c] = pop[c] && tx_last;
            busy[c] = pend[c] || (tx_valid && (tx_chan == 1'(c)));
        end
    end
endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            srst,
    input  logic            ien_we,
    input  logic            sta_we,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] set_bits,
    output logic [NSRC-1:0] ien,
    output logic [NSRC-1:0] sta,
    output logic            irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien <= '0;
            sta <= '0;
        end else if (srst) begin
            ien <= '0;
            sta <= '0;
        end else begin
            if (ien_we) ien <= wbits;
            sta <= (sta & ~(sta_we ? wbits : '0)) | set_bits;
        end
    end

    assign irq = |(sta & ien);
endmodule

// File: rtl/txq_dual_tx.sv
module txq_dual_tx
    import txq_pkg::*;
#(
    parameter int FIFO_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_event,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    output logic        tx_chan,
    input  logic        tx_ready,
    output logic        irq
);
    localparam int LW = $clog2(FIFO_BYTES) + 1;

    logic                   srst, tx_en, chsel;
    logic [LW-1:0]          len_q [NCH];
    logic [LW-1:0]          level [NCH];
    logic [7:0]             head  [NCH];
    logic [NCH-1:0]         go, pop, done, busy;
    logic [NCH-1:0][LW-1:0] eff_len;
    logic [LW-1:0]          len_clamp;
    logic [NSRC-1:0]        ien, ist;

    assign srst      = reg_wr && reg_addr == A_CTRL && reg_wdata[1];
    assign len_clamp = (reg_wdata > 32'(FIFO_BYTES)) ? LW'(FIFO_BYTES) : reg_wdata[LW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            chsel <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) tx_en <= reg_wdata[0];
            if (srst)
                chsel <= 1'b0;
            else if (reg_wr && reg_addr == A_CHSEL)
                chsel <= (reg_wdata < 32'(NCH)) ? reg_wdata[0] : 1'b0;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                len_q[c] <= '0;
            else if (srst || done[c])
                len_q[c] <= '0;
            else if (reg_wr && reg_addr == A_LEN0 + 4'(c))
                len_q[c] <= len_clamp;
        end

        assign eff_len[c] = (len_q[c] < level[c]) ? len_q[c] : level[c];
        assign go[c] = reg_wr && reg_addr == A_GO0 + 4'(c) && reg_wdata[0] && tx_en
                       && !busy[c] && eff_len[c] != '0;

        txq_byte_fifo #(.DEPTH_BYTES(FIFO_BYTES)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (srst || done[c]),
            .push      (reg_wr && reg_addr == A_DATA && chsel == 1'(c)),
            .push_word (reg_wdata),
            .pop       (pop[c]),
            .head_byte (head[c]),
            .level     (level[c])
        );
    end

    txq_send_sched #(.LW(LW)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .go       (go),
        .go_len   (eff_len),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_chan  (tx_chan),
        .pop      (pop),
        .done     (done),
        .busy     (busy)
    );

    txq_irq_ctrl #(.NSRC(NSRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .ien_we   (reg_wr && reg_addr == A_IEN),
        .sta_we   (reg_wr && reg_addr == A_ISTAT),
        .wbits    (reg_wdata[NSRC-1:0]),
        .set_bits ({rx_event, done}),
        .ien      (ien),
        .sta      (ist),
        .irq      (irq)
    );

    assign tx_data = tx_chan ? head[1] : head[0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:     reg_rdata[0] = tx_en;
            A_CHSEL:    reg_rdata[0] = chsel;
            A_LEN0:     reg_rdata[LW-1:0] = len_q[0];
            A_LEN0 + 4'd1: reg_rdata[LW-1:0] = len_q[1];
            A_IEN:      reg_rdata[NSRC-1:0] = ien;
            A_ISTAT:    reg_rdata[NSRC-1:0] = ist;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txq_dual_tx_chk.sv
module txq_dual_tx_chk
    import txq_pkg::*;
#(
    parameter int FIFO_BYTES = 2048,
    parameter int LW = $clog2(FIFO_BYTES) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          rx_event,
    input logic [7:0]    tx_data,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_chan,
    input logic          tx_ready,
    input logic          irq,
    input logic [2:0]    ist,
    input logic [LW-1:0] len0
);
    logic srst_w, done0_w;
    assign srst_w  = reg_wr && reg_addr == A_CTRL && reg_wdata[1];
    assign done0_w = tx_valid && tx_ready && tx_last && !tx_chan;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !srst_w) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_chan))); // R12
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid); // R12
    AST_DONE0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done0_w && !srst_w) |=> ist[0]); // R7
    AST_DONE1_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last && tx_chan && !srst_w) |=> ist[1]); // R7
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IEN && reg_wdata[2:0] == 3'b000) |=> !irq); // R8
    AST_W1C_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ISTAT && reg_wdata[2] && !rx_event) |=> !ist[2]); // R9
    AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_LEN0 && reg_wdata > 32'(FIFO_BYTES) && !done0_w) |=> len0 == LW'(FIFO_BYTES)); // R4
endmodule

bind txq_dual_tx txq_dual_tx_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_event  (rx_event),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_chan   (tx_chan),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .ist       (ist),
    .len0      (len_q[0])
);

// File: tb/test_txq_dual_tx.sv
`timescale 1ns/1ps
module test_txq_dual_tx;
    localparam int FB = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_event = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_chan;
    logic        tx_ready = 1'b1;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [9:0] expq [$];
    logic [7:0] mq0 [$];
    logic [7:0] mq1 [$];
    int         mlen [2];

    always #4 clk = ~clk;

    txq_dual_tx #(.FIFO_BYTES(FB)) i_txq_dual_tx (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_event(rx_event),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_chan(tx_chan), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic rd_chk(input logic [3:0] a, input int exp, input string tag);
        int v;
        rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    task automatic set_len(input int ch, input int v);
        wr(4'd2 + 4'(ch), 32'(v));
        mlen[ch] = (v > FB) ? FB : v;
    endtask

    // fill a channel with nw words; bytes are seed, seed+1, ...
    task automatic fill(input int ch, input int nw, input int seed);
        wr(4'd1, 32'(ch));
        for (int w = 0; w < nw; w++) begin
            logic [7:0] b [4];
            for (int k = 0; k < 4; k++) b[k] = 8'(seed + 4*w + k);
            wr(4'd6, {b[3], b[2], b[1], b[0]});
            if (ch == 0 && mq0.size() <= FB - 4) for (int k = 0; k < 4; k++) mq0.push_back(b[k]);
            if (ch == 1 && mq1.size() <= FB - 4) for (int k = 0; k < 4; k++) mq1.push_back(b[k]);
        end
    endtask

    // queue the bytes a send of this channel produces, then empty the model
    task automatic expect_send(input int ch);
        int sz, n;
        sz = (ch == 0) ? mq0.size() : mq1.size();
        n  = (mlen[ch] < sz) ? mlen[ch] : sz;
        for (int i = 0; i < n; i++)
            expq.push_back({(i == n - 1) ? 1'b1 : 1'b0, 1'(ch), (ch == 0) ? mq0[i] : mq1[i]});
        if (ch == 0) mq0.delete(); else mq1.delete();
        mlen[ch] = 0;
    endtask

    task automatic drain;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #2;
            if (expq.size() == 0 && !tx_valid) break;
        end
        check(expq.size() == 0, "R12 drain", expq.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (rst_n && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R5 unexpected byte", int'(tx_data), -1);
            end else begin
                logic [9:0] e;
                e = expq.pop_front();
                check({tx_last, tx_chan, tx_data} == e, "R2 R12 byte/chan/last",
                      int'({tx_last, tx_chan, tx_data}), int'(e));
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int v;
        mlen[0] = 0; mlen[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R11)
        rd_chk(4'd0, 0, "R11 ctrl reset");
        rd_chk(4'd8, 0, "R11 status reset");
        rd_chk(4'd2, 0, "R11 len0 reset");
        check(!irq && !tx_valid, "R11 outputs reset", int'({irq, tx_valid}), 0);

        // R1 channel select
        wr(4'd1, 32'd1);  rd_chk(4'd1, 1, "R1 select 1");
        wr(4'd1, 32'd5);  rd_chk(4'd1, 0, "R1 select 5");
        wr(4'd1, 32'd1);  wr(4'd1, 32'd2); rd_chk(4'd1, 0, "R1 select 2");

        // R4 length clamp
        set_len(0, 100); rd_chk(4'd2, FB, "R4 clamp 100");
        set_len(1, 65);  rd_chk(4'd3, FB, "R4 clamp 65");
        set_len(0, 10);  rd_chk(4'd2, 10, "R4 plain 10");

        // R5 start ignored while transmit disabled
        fill(0, 2, 8'h10); set_len(0, 8);
        wr(4'd4, 32'd1);
        repeat (4) @(negedge clk);
        check(!tx_valid, "R5 disabled no send", int'(tx_valid), 0);
        rd_chk(4'd8, 0, "R5 disabled no status");

        // enable, send 8 bytes (R2, R6, R7)
        wr(4'd0, 32'd1);
        wr(4'd4, 32'd1); expect_send(0);
        drain();
        rd_chk(4'd8, 1, "R7 ch0 status");
        rd_chk(4'd2, 0, "R6 len0 cleared");

        // R5 length limited by fill on ch1
        fill(1, 3, 8'h40); set_len(1, 20);
        wr(4'd5, 32'd1); expect_send(1);
        drain();
        rd_chk(4'd8, 3, "R7 ch1 status");

        // R5 short length, R6 leftover discarded
        fill(0, 3, 8'h60); set_len(0, 5);
        wr(4'd4, 32'd1); expect_send(0);
        drain();
        fill(0, 1, 8'h90); set_len(0, 4);
        wr(4'd4, 32'd1); expect_send(0);
        drain();

        // R5 zero length sends nothing
        wr(4'd8, 32'd7);
        fill(0, 1, 8'hA0); set_len(0, 0);
        wr(4'd4, 32'd1);
        repeat (4) @(negedge clk);
        check(!tx_valid, "R5 zero length", int'(tx_valid), 0);
        rd_chk(4'd8, 0, "R5 zero length no status");
        wr(4'd0, 32'd3); mq0.delete(); mlen[0] = 0; mlen[1] = 0;

        // R12 backpressure
        fill(1, 4, 8'h20); set_len(1, 16);
        wr(4'd5, 32'd1); expect_send(1);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            tx_ready = (i % 3) != 1;
        end
        @(negedge clk); tx_ready = 1'b1;
        drain();

        // R13 priority, R14 repeat start ignored
        @(negedge clk); tx_ready = 1'b0;
        fill(1, 2, 8'hC0); set_len(1, 8);
        fill(0, 2, 8'hD0); set_len(0, 8);
        wr(4'd5, 32'd1);
        wr(4'd4, 32'd1);
        wr(4'd2, 32'd4);   // length rewrite after start
        wr(4'd4, 32'd1);   // repeat start on queued channel
        repeat (3) @(negedge clk);
        check(!tx_valid, "R13 wait for ready", int'(tx_valid), 0);
        expect_send(0); expect_send(1);
        @(negedge clk); tx_ready = 1'b1;
        drain();
        rd_chk(4'd2, 0, "R14 len0 cleared after send");

        // R3 full queue drops 17th word
        fill(0, 17, 8'h01); set_len(0, FB);
        wr(4'd4, 32'd1); expect_send(0);
        drain();

        // R8 R9 R10 interrupts
        wr(4'd8, 32'd7); wr(4'd7, 32'd0);
        @(negedge clk); rx_event = 1'b1;
        @(negedge clk); rx_event = 1'b0;
        rd_chk(4'd8, 4, "R10 rx event flag");
        check(!irq, "R8 masked", int'(irq), 0);
        wr(4'd7, 32'd4);
        @(negedge clk); #1;
        check(irq, "R8 enabled", int'(irq), 1);
        wr(4'd8, 32'd1);
        rd_chk(4'd8, 4, "R9 other bit kept");
        wr(4'd8, 32'd4);
        rd_chk(4'd8, 0, "R9 cleared");
        check(!irq, "R8 after clear", int'(irq), 0);
        wr(4'd7, 32'd2);
        fill(1, 1, 8'h77); set_len(1, 4);
        wr(4'd5, 32'd1); expect_send(1);
        drain();
        check(irq, "R8 ch1 done irq", int'(irq), 1);

        // R11 soft reset
        fill(1, 2, 8'h33); set_len(1, 8); wr(4'd7, 32'd7);
        wr(4'd0, 32'd3);
        mq1.delete(); mlen[1] = 0;
        rd_chk(4'd0, 1, "R11 reset bit not stored");
        rd_chk(4'd3, 0, "R11 len1 cleared");
        rd_chk(4'd1, 0, "R11 chsel cleared");
        rd_chk(4'd7, 0, "R11 enable cleared");
        rd_chk(4'd8, 0, "R11 status cleared");
        set_len(1, 8);
        wr(4'd5, 32'd1);
        repeat (4) @(negedge clk);
        check(!tx_valid, "R11 queue emptied", int'(tx_valid), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule